// File: doc/BRIEF.md
# 100BASE-TX Transmit Code-Group Encoder

This block sits on the transmit side of a Fast Ethernet physical coding layer. Once per nibble clock it takes one 4-bit transmit nibble, together with a frame-enable and an error flag, and produces one 5-bit code group. While no frame is active it sends the idle code group. When a frame begins, the encoder replaces the first byte of preamble (two nibbles) with the start-of-stream delimiter pair. It then translates every further nibble through the fixed 4B/5B data table. When the enable falls, it closes the stream with the end-of-stream delimiter pair and returns to idle.

An error flag raised inside a frame turns that nibble's data code group into the HALT code group. The delimiters are never corrupted this way. The code group is registered. Serialization, scrambling and line coding happen downstream and are outside this block.

Top module: `tx_cg_encoder`

## Requirements
- R1: With tx_en high in the data phase and tx_err low, a nibble n maps to code_out (written code_out[4:0]) as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: When tx_en is first seen high while idle, the nibbles of that cycle and the next are replaced by J (11000) and then K (10001).
- R3: When tx_en is seen low after K or during data, the encoder emits T (01101) and then R (00111).
- R4: Outside a frame, and after R when tx_en is low, code_out is IDLE (11111) on every cycle.
- R5: A data-phase nibble sampled with tx_en and tx_err both high produces HALT (00100) in place of its data code group.
- R6: J, K, T and R are emitted unchanged whatever the value of tx_err.
- R7: If tx_en falls while J or K is being sent, J and K still both complete, and T and R follow at once with no data code group.
- R8: If tx_en is high while T or R is being sent, R is still sent, and the next frame's J follows directly after R.
- R9: code_out is registered: an input sampled at a clock edge determines the code group that appears right after that same edge.
- R10: A synchronous active-high rst forces code_out to IDLE and ends any frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_nib | input | 4 | Transmit nibble |
| tx_en | input | 1 | Frame enable |
| tx_err | input | 1 | Transmit error flag |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
On every cycle, the bound checker tracks the delimiter order: J is followed by K, T by R, and R by either IDLE or J depending on the enable. It also checks that a frame starting from idle always begins with J regardless of the error flag. In addition, it compares each data-phase output against the mapped or HALT code of the nibble sampled one edge earlier, and it confirms that the output is idle right after reset. Whole-frame patterns can only be shown by the bench's scenarios. These include an enable that drops during J or K, an enable that rises again during the closing delimiters, a reset in mid-frame, and a sweep of all sixteen nibble values.

// File: rtl/tx_enc_pkg.sv
package tx_enc_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;
  localparam int ST_W  = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_J    = 3'd1,
    ST_K    = 3'd2,
    ST_DATA = 3'd3,
    ST_T    = 3'd4,
    ST_R    = 3'd5
  } enc_state_t;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_HALT = 5'b00100;

  function automatic logic [SYM_W-1:0] nib_to_cg(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tx_enc_fsm.sv
module tx_enc_fsm
  import tx_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  output enc_state_t state_q,
  output enc_state_t state_d
);
  // Next state is the phase that the code group emitted at this edge belongs to.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = tx_en ? ST_J : ST_IDLE;
      ST_J:    state_d = ST_K;                 // K always completes
      ST_K:    state_d = tx_en ? ST_DATA : ST_T;
      ST_DATA: state_d = tx_en ? ST_DATA : ST_T;
      ST_T:    state_d = ST_R;                 // R always completes
      ST_R:    state_d = tx_en ? ST_J : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/tx_enc_symsel.sv
module tx_enc_symsel
  import tx_enc_pkg::*;
(
  input  enc_state_t       phase,
  input  logic [NIB_W-1:0] nib,
  input  logic             err,
  output logic [SYM_W-1:0] sym
);
  always_comb begin
    unique case (phase)
      ST_J:    sym = CG_J;
      ST_K:    sym = CG_K;
      ST_DATA: sym = err ? CG_HALT : nib_to_cg(nib);
      ST_T:    sym = CG_T;
      ST_R:    sym = CG_R;
      default: sym = CG_IDLE;
    endcase
  end
endmodule

// File: rtl/tx_enc_oreg.sv
module tx_enc_oreg #(
  parameter int          W         = 5,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/tx_cg_encoder.sv
module tx_cg_encoder
  import tx_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] tx_nib,
  input  logic             tx_en,
  input  logic             tx_err,
  output logic [SYM_W-1:0] code_out
);
  enc_state_t       st_q;
  enc_state_t       st_d;
  logic [SYM_W-1:0] sym_d;

  tx_enc_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .state_q (st_q),
    .state_d (st_d)
  );

  tx_enc_symsel u_sel (
    .phase (st_d),
    .nib   (tx_nib),
    .err   (tx_err & tx_en),
    .sym   (sym_d)
  );

  tx_enc_oreg #(.W(SYM_W), .RESET_VAL(CG_IDLE)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (sym_d),
    .q   (code_out)
  );
endmodule

// File: rtl/tx_cg_encoder_chk.sv
module tx_cg_encoder_chk
  import tx_enc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NIB_W-1:0] tx_nib,
  input logic             tx_en,
  input logic             tx_err,
  input logic [SYM_W-1:0] code_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  function automatic logic in_body(input logic [SYM_W-1:0] c);
    return (c == CG_K) || (c == CG_HALT) ||
           (c != CG_IDLE && c != CG_J && c != CG_T && c != CG_R && c != 5'b00000);
  endfunction

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> code_out == CG_IDLE);

  assert_data_map_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(tx_en) && !$past(tx_err) && in_body($past(code_out)))
      |-> code_out == nib_to_cg($past(tx_nib)));

  assert_halt_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(tx_en) && $past(tx_err) && in_body($past(code_out)))
      |-> code_out == CG_HALT);

  assert_start_j_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(tx_en) && ($past(code_out) == CG_IDLE || $past(code_out) == CG_R))
      |-> code_out == CG_J);

  assert_j_then_k_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(code_out) == CG_J) |-> code_out == CG_K);

  assert_end_t_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(tx_en) && in_body($past(code_out))) |-> code_out == CG_T);

  assert_t_then_r_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(code_out) == CG_T) |-> code_out == CG_R);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(tx_en) && ($past(code_out) == CG_IDLE || $past(code_out) == CG_R))
      |-> code_out == CG_IDLE);
endmodule

bind tx_cg_encoder tx_cg_encoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_nib   (tx_nib),
  .tx_en    (tx_en),
  .tx_err   (tx_err),
  .code_out (code_out)
);

// File: tb/tx_cg_encoder_tb.sv
module tx_cg_encoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tx_nib = 4'h0;
  logic       tx_en = 1'b0;
  logic       tx_err = 1'b0;
  logic [4:0] code_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tx_cg_encoder u_dut (
    .clk(clk), .rst(rst), .tx_nib(tx_nib), .tx_en(tx_en),
    .tx_err(tx_err), .code_out(code_out)
  );

  localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001;
  localparam logic [4:0] T_ = 5'b01101, R_ = 5'b00111, H_ = 5'b00100;

  function automatic logic [4:0] exp_map(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  // {rst, en, err, nib[3:0], expected code after the edge[4:0]}
  localparam int NV = 20;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'h0, 5'b11111},  // R10 reset
    {1'b0, 1'b0, 1'b0, 4'h3, 5'b11111},  // R4 idle
    {1'b0, 1'b1, 1'b0, 4'h5, 5'b11000},  // R2 J
    {1'b0, 1'b1, 1'b0, 4'h5, 5'b10001},  // R2 K
    {1'b0, 1'b1, 1'b0, 4'h0, 5'b11110},  // R1
    {1'b0, 1'b1, 1'b0, 4'hF, 5'b11101},  // R1
    {1'b0, 1'b1, 1'b1, 4'hA, 5'b00100},  // R5 halt
    {1'b0, 1'b1, 1'b0, 4'h9, 5'b10011},  // R1
    {1'b0, 1'b0, 1'b0, 4'h0, 5'b01101},  // R3 T
    {1'b0, 1'b0, 1'b0, 4'h0, 5'b00111},  // R3 R
    {1'b0, 1'b0, 1'b0, 4'h0, 5'b11111},  // R4
    {1'b0, 1'b1, 1'b1, 4'h2, 5'b11000},  // R6 J despite err
    {1'b0, 1'b1, 1'b1, 4'h2, 5'b10001},  // R6 K despite err
    {1'b0, 1'b0, 1'b1, 4'h2, 5'b01101},  // R6 T
    {1'b0, 1'b1, 1'b1, 4'h2, 5'b00111},  // R8 R despite en
    {1'b0, 1'b1, 1'b0, 4'h7, 5'b11000},  // R8 J right after R
    {1'b0, 1'b0, 1'b0, 4'h7, 5'b10001},  // R7 K completes
    {1'b0, 1'b0, 1'b0, 4'h7, 5'b01101},  // R7 T follows
    {1'b0, 1'b0, 1'b0, 4'h7, 5'b00111},  // R7 R
    {1'b0, 1'b0, 1'b0, 4'h7, 5'b11111}   // R4
  };

  task automatic step(input logic r, input logic e, input logic x, input logic [3:0] n);
    rst = r; tx_en = e; tx_err = x; tx_nib = n;
    @(negedge clk);
  endtask

  task automatic chk(input logic [4:0] exp, input string req);
    n_chk++;
    if (code_out !== exp) begin
      n_fail++;
      $display("FAIL %s: code_out=%b expected=%b", req, code_out, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      chk(VEC[i][4:0], $sformatf("vector %0d (R9 one-edge latency)", i));
    end

    // R1: all sixteen nibbles, each visible right after its sampling edge
    step(1'b0, 1'b1, 1'b0, 4'h5); chk(J_, "R2 sweep J");
    step(1'b0, 1'b1, 1'b0, 4'h5); chk(K_, "R2 sweep K");
    for (int n = 0; n < 16; n++) begin
      step(1'b0, 1'b1, 1'b0, 4'(n));
      chk(exp_map(4'(n)), $sformatf("R1 nibble %0h", n));
    end
    step(1'b0, 1'b1, 1'b1, 4'h3); chk(H_, "R5 halt at frame end");
    step(1'b0, 1'b0, 1'b1, 4'h3); chk(T_, "R3/R6 T with err");
    step(1'b0, 1'b0, 1'b0, 4'h3); chk(R_, "R3 R");
    step(1'b0, 1'b0, 1'b0, 4'h3); chk(I_, "R4 idle");

    // R7: enable only during J
    step(1'b0, 1'b1, 1'b0, 4'h1); chk(J_, "R7 J");
    step(1'b0, 1'b0, 1'b0, 4'h1); chk(K_, "R7 K");
    step(1'b0, 1'b0, 1'b0, 4'h1); chk(T_, "R7 T");
    step(1'b0, 1'b1, 1'b0, 4'h1); chk(R_, "R8 R with en high");
    step(1'b0, 1'b1, 1'b0, 4'h1); chk(J_, "R8 J after R");
    step(1'b0, 1'b1, 1'b0, 4'h1); chk(K_, "R2 K");
    step(1'b0, 1'b1, 1'b0, 4'hC); chk(exp_map(4'hC), "R1 data");

    // R10: reset in mid-frame
    step(1'b1, 1'b1, 1'b0, 4'hC); chk(I_, "R10 reset mid-frame");
    step(1'b0, 1'b0, 1'b0, 4'hC); chk(I_, "R10 idle after reset");
    step(1'b0, 1'b1, 1'b1, 4'hC); chk(J_, "R10/R6 fresh frame J");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule